// File: doc/BRIEF.md
# Memory Read Fault Status Register

This block records how reads from a non-volatile memory array turned out and keeps that outcome in a byte-wide status register. Software can read the register and clear it. The array read path pulses a strobe once for each read. On that cycle the block samples three things: the error-correction result (a corrected one-bit error or an uncorrectable two-bit error), the busy state of the memory controller, and a configuration bit that suppresses single-bit reporting. From these it sets one or both of two sticky flags.

A genuine error-correction fault sets exactly one flag. A read that arrives while the controller is still running a command is an access collision. A collision sets both flags together, so software can tell a third condition apart without a third bit. Each flag also drives an interrupt-request line. The line stays high until software writes 1 to that flag's bit.

Top module: `fault_status_reg`

## Requirements
- R1: After reset both flags are 0. A read of the register returns 0x00, and both interrupt lines are low.
- R2: Bits 7..2 of the register always read 0. Writing 1s to them changes nothing.
- R3: Writing 1 to bit 0 clears the single-bit flag, and writing 1 to bit 1 clears the double-bit flag. Writing 0 to either bit leaves that flag unchanged.
- R4: A strobed read outside a command with an uncorrectable two-bit error sets the double-bit flag (bit 1). The single-bit flag is left unchanged.
- R5: A strobed read outside a command with a corrected one-bit error sets the single-bit flag (bit 0), but only while the ignore-single input is 0. While that input is 1 the flag is left unchanged.
- R6: A genuine error never sets both flags. If both error indications arrive on the same strobed read, only the double-bit flag is set.
- R7: A strobed read while the controller is busy sets both flags, whatever the error indications and the ignore-single input.
- R8: Without a read strobe, the error, busy and ignore inputs have no effect, and both flags hold their value.
- R9: If a hardware set and a software write-1 clear hit the same flag in the same cycle, the flag ends at 1.
- R10: `irq_df` always equals the double-bit flag, and `irq_sf` always equals the single-bit flag.
- R11: The register answers only at offset `REG_ADDR` (default 7) while `bus_sel` is high. At any other offset, reads return 0x00 and writes clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One pulse per array read attempt |
| ecc_sbe | input | 1 | Corrected one-bit error on this read |
| ecc_dbe | input | 1 | Uncorrectable two-bit error on this read |
| cmd_busy | input | 1 | Memory controller is executing a command |
| ign_sf | input | 1 | Suppress single-bit fault reporting |
| bus_sel | input | 1 | Register bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data, a 1 clears the flag in that bit |
| bus_rdata | output | DATA_W | Read data, 0 when not addressed |
| irq_df | output | 1 | Double-bit fault interrupt request |
| irq_sf | output | 1 | Single-bit fault interrupt request |

## Verification
The strobed read is tried with five patterns:
- a lone two-bit error;
- a lone one-bit error with suppression off and with suppression on;
- both error indications together;
- a busy-controller read with no error indication and suppression on.

These separate the bit-1-only, bit-0-only, nothing and both-bits outcomes. The bench also holds error and busy inputs high without a strobe, to show that sampling is gated by the strobe. It clears a flag in the same cycle one is set, to show which side wins. Finally, it writes to a wrong offset and with reserved or zero bits, to show that only a 1 at the right offset clears.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int unsigned FLAG_SF   = 0;
   localparam int unsigned FLAG_DF   = 1;
   localparam int unsigned NUM_FLAGS = 2;

   typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/fsr_event_dec.sv
module fsr_event_dec
   import fsr_pkg::*;
(
   input  logic      rd_stb,
   input  logic      ecc_sbe,
   input  logic      ecc_dbe,
   input  logic      cmd_busy,
   input  logic      ign_sf,
   output flag_vec_t set_vec
);
   // Collision outranks any error result; a two-bit error outranks a one-bit one.
   always_comb begin
      set_vec = '0;
      if (rd_stb) begin
         if (cmd_busy) begin
            set_vec[FLAG_DF] = 1'b1;
            set_vec[FLAG_SF] = 1'b1;
         end else if (ecc_dbe) begin
            set_vec[FLAG_DF] = 1'b1;
         end else if (ecc_sbe && !ign_sf) begin
            set_vec[FLAG_SF] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fsr_flag_cell.sv
module fsr_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // Set has priority over a same-cycle clear.
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/fsr_bus_if.sv
module fsr_bus_if
   import fsr_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned REG_ADDR = 7
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  flag_vec_t         flags,
   output flag_vec_t         clr_vec,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int unsigned RSV_W = DATA_W - NUM_FLAGS;
   localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);

   logic hit;
   logic [DATA_W-1:0] view;

   assign hit = bus_sel && (bus_addr == REG_A);

   generate
      if (RSV_W > 0) begin : g_rsv
         assign view = {{RSV_W{1'b0}}, flags};
      end else begin : g_norsv
         assign view = flags;
      end
   endgenerate

   assign clr_vec   = (hit && bus_wr) ? bus_wdata[NUM_FLAGS-1:0] : '0;
   assign bus_rdata = (hit && !bus_wr) ? view : '0;
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
   import fsr_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned REG_ADDR = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              ecc_sbe,
   input  logic              ecc_dbe,
   input  logic              cmd_busy,
   input  logic              ign_sf,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_df,
   output logic              irq_sf
);
   generate
      if (DATA_W < NUM_FLAGS) begin : g_bad_width
         $error("DATA_W must hold both flags");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("ADDR_W out of range");
      end
      if (REG_ADDR >= (1 << ADDR_W)) begin : g_bad_offset
         $error("REG_ADDR does not fit in ADDR_W");
      end
   endgenerate

   flag_vec_t set_vec;
   flag_vec_t clr_vec;
   flag_vec_t flags;

   fsr_event_dec u_dec (
      .rd_stb   (rd_stb),
      .ecc_sbe  (ecc_sbe),
      .ecc_dbe  (ecc_dbe),
      .cmd_busy (cmd_busy),
      .ign_sf   (ign_sf),
      .set_vec  (set_vec)
   );

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         fsr_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_vec[i]),
            .clr   (clr_vec[i]),
            .q     (flags[i])
         );
      end
   endgenerate

   fsr_bus_if #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR)
   ) u_bus (
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .flags     (flags),
      .clr_vec   (clr_vec),
      .bus_rdata (bus_rdata)
   );

   assign irq_df = flags[FLAG_DF];
   assign irq_sf = flags[FLAG_SF];
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned REG_ADDR = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_stb,
   input logic              ecc_sbe,
   input logic              ecc_dbe,
   input logic              cmd_busy,
   input logic              ign_sf,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq_df,
   input logic              irq_sf
);
   logic hit, wr_hit, rd_hit;
   assign hit    = bus_sel && (bus_addr == ADDR_W'(REG_ADDR));
   assign wr_hit = hit && bus_wr;
   assign rd_hit = hit && !bus_wr;

   // R3
   sf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && bus_wdata[0] && !rd_stb) |=> !irq_sf);

   // R7
   collision_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && cmd_busy) |=> (irq_df && irq_sf));

   // R4
   df_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !cmd_busy && ecc_dbe && !wr_hit) |=> (irq_df && $stable(irq_sf)));

   // R5
   sf_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !cmd_busy && !ecc_dbe && ign_sf && !wr_hit) |=> ($stable(irq_sf) && $stable(irq_df)));

   // R8
   hold_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && !wr_hit) |=> ($stable(irq_sf) && $stable(irq_df)));

   // R10
   irq_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> (bus_rdata == {{(DATA_W-2){1'b0}}, irq_df, irq_sf}));

   // R11
   no_hit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (bus_rdata == '0));
endmodule

bind fault_status_reg fsr_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .REG_ADDR (REG_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_stb    (rd_stb),
   .ecc_sbe   (ecc_sbe),
   .ecc_dbe   (ecc_dbe),
   .cmd_busy  (cmd_busy),
   .ign_sf    (ign_sf),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_df    (irq_df),
   .irq_sf    (irq_sf)
);

// File: tb/fault_status_reg_tb.sv
module fault_status_reg_tb;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] REG_A = 4'd7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_stb = 0, ecc_sbe = 0, ecc_dbe = 0, cmd_busy = 0, ign_sf = 0;
   logic bus_sel = 0, bus_wr = 0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic irq_df, irq_sf;

   always #2 clk = ~clk;

   fault_status_reg u_dut (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .ecc_sbe(ecc_sbe),
      .ecc_dbe(ecc_dbe), .cmd_busy(cmd_busy), .ign_sf(ign_sf),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_df(irq_df), .irq_sf(irq_sf)
   );

   typedef struct {
      logic [DATA_W-1:0] exp;
      string             tag;
   } item_t;

   item_t q[$];
   event  mon_ev;
   int    n_checks = 0;
   int    n_err = 0;
   logic [1:0] model = 2'b00;

   // Monitor: pops expected items and compares read data and interrupt lines.
   initial begin
      forever begin
         @(mon_ev);
         #1;
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_checks++;
            if (bus_rdata !== it.exp) begin
               n_err++;
               $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
            end
            n_checks++;
            if ({irq_df, irq_sf} !== it.exp[1:0]) begin
               n_err++;
               $display("FAIL R10 (%s): irq=%b expected=%b", it.tag, {irq_df, irq_sf}, it.exp[1:0]);
            end
         end
      end
   end

   // Driver: one stimulus cycle, model update, then a register read pushed to the scoreboard.
   task automatic step(input logic rs, input logic sb, input logic db, input logic bz,
                       input logic ig, input logic sel, input logic wr,
                       input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                       input string tag);
      logic [1:0] set_m, clr_m;
      @(negedge clk);
      rd_stb = rs; ecc_sbe = sb; ecc_dbe = db; cmd_busy = bz; ign_sf = ig;
      bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      set_m = 2'b00;
      if (rs && bz) set_m = 2'b11;
      else if (rs && db) set_m = 2'b10;
      else if (rs && sb && !ig) set_m = 2'b01;
      clr_m = (sel && wr && a == REG_A) ? wd[1:0] : 2'b00;
      model = set_m | (model & ~clr_m);
      @(negedge clk);
      rd_stb = 0; ecc_sbe = 0; ecc_dbe = 0; cmd_busy = 0; ign_sf = 0;
      bus_sel = 1; bus_wr = 0; bus_addr = REG_A; bus_wdata = '0;
      q.push_back('{exp: {6'b0, model}, tag: tag});
      -> mon_ev;
      #1.5;
   endtask

   task automatic read_other(input logic [ADDR_W-1:0] a, input string tag);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1;
      n_checks++;
      if (bus_rdata !== '0) begin
         n_err++;
         $display("FAIL %s: rdata=%h expected=00", tag, bus_rdata);
      end
      bus_sel = 0;
   endtask

   bit done = 0;
   initial begin
      #(200000 * 4);
      if (!done) begin
         n_err++;
         n_checks++;
         $display("FAIL watchdog: run hung");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      step(0,0,0,0,0, 0,0,4'd0,8'h00, "R1 reset state");
      step(1,0,1,0,0, 0,0,4'd0,8'h00, "R4 two-bit error sets bit1");
      step(0,0,0,0,0, 1,1,REG_A,8'h00, "R3 write zero keeps flag");
      step(0,0,0,0,0, 1,1,REG_A,8'hFC, "R2 reserved write ignored");
      step(0,0,0,0,0, 1,1,REG_A,8'h02, "R3 write one clears bit1");
      step(1,1,0,0,0, 0,0,4'd0,8'h00, "R5 one-bit error sets bit0");
      step(0,0,0,0,0, 1,1,REG_A,8'h01, "R3 write one clears bit0");
      step(1,1,0,0,1, 0,0,4'd0,8'h00, "R5 one-bit error suppressed");
      step(1,1,1,0,0, 0,0,4'd0,8'h00, "R6 both indications set bit1 only");
      step(0,0,0,0,0, 1,1,REG_A,8'h03, "R3 clear both");
      step(1,0,0,1,1, 0,0,4'd0,8'h00, "R7 collision sets both");
      step(0,0,0,0,0, 1,1,REG_A,8'hFF, "R3 clear after collision");
      step(0,1,1,1,0, 0,0,4'd0,8'h00, "R8 no strobe no set");
      step(1,0,1,0,0, 0,0,4'd0,8'h00, "R4 set bit1 again");
      step(0,1,0,1,0, 0,0,4'd0,8'h00, "R8 flags hold without strobe");
      step(1,0,1,0,0, 1,1,REG_A,8'h02, "R9 set wins over clear");
      step(1,1,0,1,0, 1,1,REG_A,8'h03, "R9 collision beats clear");
      step(0,0,0,0,0, 1,1,4'd3,8'h03, "R11 wrong offset write ignored");
      read_other(4'd3, "R11 wrong offset reads zero");
      @(negedge clk) bus_sel = 0;
      step(0,0,0,0,0, 0,1,REG_A,8'h03, "R11 unselected write ignored");
      step(0,0,0,0,0, 1,1,REG_A,8'h03, "R3 final clear");
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule